// File: doc/BRIEF.md
# Accelerator Signal Edge Timestamper

This block tags edges of two asynchronous accelerator timing inputs with a free-running 64-bit master timestamp. The first input is the fast bi-phase (Manchester) coded accelerator clock/data stream at 10 Mbit/s. The second input is a separate strobe that marks message boundaries. The timestamp counter runs in the 62.5 MHz master clock domain, which is derived from a GPS-disciplined reference. It counts up by one every cycle and can be loaded synchronously with an absolute time.

Each input passes through its own synchroniser and rising-edge detector. Every strobe edge produces a record. Stream edges come at millions per second, so they are thinned by a programmable decimation factor. The records that remain are enough to follow how the stream phase drifts against the master clock.

Records leave through a single-entry valid/ready output stage that carries a source tag. Records that cannot be delivered are counted and not queued. A strobe record always wins over a stream record in the same cycle, and the losing stream sample is counted as a drop.

Top module: `acc_edge_stamper`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, `out_valid` is 0 and both `drop_cnt` and `ovf_cnt` are 0.
- R2: The timestamp advances by one per clock and wraps at 2^64. When `ts_load` is high at a clock edge, that edge instead sets the timestamp to `ts_load_val`.
- R3: Each input goes through a two-flop synchroniser. If an input is first sampled high at edge k, its record carries the timestamp value held between edges k+1 and k+2, and `out_valid` rises at edge k+2.
- R4: Falling edges and levels held high make no record. A strobe held high for many cycles yields exactly one record.
- R5: Every strobe rising edge yields a record with `out_src` = 1, provided the output slot is free or is being emptied in that cycle.
- R6: With `decim_n` = N ≥ 1, only every Nth stream rising edge yields a record, with `out_src` = 0. If the edge count is already at or past N−1 when an edge arrives, that edge is emitted.
- R7: With `decim_n` = 0, no stream record is produced and the edge count is held at 0. After N is made nonzero, the Nth following edge is the first one emitted.
- R8: If a strobe record and a stream record appear in the same cycle, the strobe record is offered and the stream record is discarded, and `drop_cnt` goes up by one.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_ts` and `out_src` hold their values.
- R10: A record that appears while `out_valid` is 1 and `out_ready` is 0 is discarded and `ovf_cnt` goes up by one. A record that appears in the cycle where the held record is accepted replaces it with no loss.
- R11: `drop_cnt` and `ovf_cnt` saturate at 2^CNT_W − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_load | input | 1 | Load the timestamp counter at this edge |
| ts_load_val | input | TS_W | Value to load into the timestamp |
| decim_n | input | DEC_W | Stream decimation factor; 0 disables stream records |
| stream_in | input | 1 | Asynchronous coded accelerator clock/data stream |
| strobe_in | input | 1 | Asynchronous message-boundary strobe |
| out_valid | output | 1 | A record is offered |
| out_ready | input | 1 | The consumer accepts the offered record |
| out_ts | output | TS_W | Timestamp of the record |
| out_src | output | 1 | 1 = strobe, 0 = stream |
| drop_cnt | output | CNT_W | Stream records lost to strobe priority |
| ovf_cnt | output | CNT_W | Records lost because the output was stalled |

## Verification
The bench builds the block with TS_W=64, DEC_W=4 and CNT_W=3. The 3-bit counters reach saturation after only a handful of stalled strobe pulses. The 4-bit decimation field lets random runs switch between factors 0 to 4, and those small factors make decimated stream records frequent enough to collide with strobes and with stalls. The full 64-bit timestamp is kept so that a load to all-ones checks the wrap to zero.

// File: rtl/acc_stamp_pkg.sv
package acc_stamp_pkg;

    // Source tag carried with each record
    typedef enum logic {
        SRC_STREAM = 1'b0,
        SRC_STROBE = 1'b1
    } src_e;

    // Output slot state
    typedef enum logic {
        OS_EMPTY = 1'b0,
        OS_FULL  = 1'b1
    } out_state_e;

    localparam int NUM_INPUTS = 2;
    localparam int IDX_STREAM = 0;
    localparam int IDX_STROBE = 1;

endpackage

// File: rtl/acc_edge_sync.sv
module acc_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], async_in};
        end
    end

    // synchronised level versus its previous sample
    assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

endmodule

// File: rtl/acc_ts_counter.sv
module acc_ts_counter #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TS_W-1:0] load_val,
    output logic [TS_W-1:0] ts
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts <= '0;
        end else if (load) begin
            ts <= load_val;
        end else begin
            ts <= ts + TS_W'(1);
        end
    end
endmodule

// File: rtl/acc_decimator.sv
module acc_decimator #(
    parameter int DEC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic [DEC_W-1:0] decim_n,
    output logic             emit
);
    logic [DEC_W-1:0] cnt_q;
    logic             enabled;
    logic             at_limit;

    assign enabled  = (decim_n != '0);
    assign at_limit = (cnt_q >= decim_n - DEC_W'(1));
    assign emit     = rise && enabled && at_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enabled) begin
            cnt_q <= '0;
        end else if (rise) begin
            cnt_q <= at_limit ? '0 : cnt_q + DEC_W'(1);
        end
    end
endmodule

// File: rtl/acc_out_fsm.sv
module acc_out_fsm
    import acc_stamp_pkg::*;
#(
    parameter int TS_W  = 64,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_rise,
    input  logic             stream_emit,
    input  logic [TS_W-1:0]  ts_now,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [TS_W-1:0]  out_ts,
    output logic             out_src,
    output logic [CNT_W-1:0] drop_cnt,
    output logic [CNT_W-1:0] ovf_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    out_state_e state_q, state_d;
    logic       cand, slot_free, do_load, do_lose, collide;
    src_e       cand_src;

    assign cand      = strobe_rise | stream_emit;
    assign cand_src  = strobe_rise ? SRC_STROBE : SRC_STREAM;
    assign collide   = strobe_rise & stream_emit;
    assign slot_free = (state_q == OS_EMPTY) || out_ready;
    assign do_load   = cand && slot_free;
    assign do_lose   = cand && !slot_free;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OS_EMPTY;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_EMPTY: state_d = cand ? OS_FULL : OS_EMPTY;
            OS_FULL: begin
                if (out_ready) state_d = cand ? OS_FULL : OS_EMPTY;
                else           state_d = OS_FULL;
            end
            default: state_d = OS_EMPTY;
        endcase
    end

    // payload and loss counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_ts   <= '0;
            out_src  <= 1'b0;
            drop_cnt <= '0;
            ovf_cnt  <= '0;
        end else begin
            if (do_load) begin
                out_ts  <= ts_now;
                out_src <= cand_src;
            end
            if (do_lose && ovf_cnt != CNT_MAX)
                ovf_cnt <= ovf_cnt + CNT_W'(1);
            if (collide && drop_cnt != CNT_MAX)
                drop_cnt <= drop_cnt + CNT_W'(1);
        end
    end

    assign out_valid = (state_q == OS_FULL);

endmodule

// File: rtl/acc_edge_stamper.sv
module acc_edge_stamper
    import acc_stamp_pkg::*;
#(
    parameter int TS_W        = 64,
    parameter int DEC_W       = 16,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ts_load,
    input  logic [TS_W-1:0]  ts_load_val,
    input  logic [DEC_W-1:0] decim_n,
    input  logic             stream_in,
    input  logic             strobe_in,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [TS_W-1:0]  out_ts,
    output logic             out_src,
    output logic [CNT_W-1:0] drop_cnt,
    output logic [CNT_W-1:0] ovf_cnt
);
    logic [NUM_INPUTS-1:0] raw_in;
    logic [NUM_INPUTS-1:0] rise_vec;
    logic [TS_W-1:0]       ts_now;
    logic                  strobe_rise;
    logic                  stream_emit;

    assign raw_in[IDX_STREAM] = stream_in;
    assign raw_in[IDX_STROBE] = strobe_in;

    for (genvar g = 0; g < NUM_INPUTS; g++) begin : g_sync
        acc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw_in[g]),
            .rise     (rise_vec[g])
        );
    end

    assign strobe_rise = rise_vec[IDX_STROBE];

    acc_ts_counter #(.TS_W(TS_W)) u_ts (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ts_load),
        .load_val (ts_load_val),
        .ts       (ts_now)
    );

    acc_decimator #(.DEC_W(DEC_W)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise_vec[IDX_STREAM]),
        .decim_n (decim_n),
        .emit    (stream_emit)
    );

    acc_out_fsm #(.TS_W(TS_W), .CNT_W(CNT_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_rise (strobe_rise),
        .stream_emit (stream_emit),
        .ts_now      (ts_now),
        .out_ready   (out_ready),
        .out_valid   (out_valid),
        .out_ts      (out_ts),
        .out_src     (out_src),
        .drop_cnt    (drop_cnt),
        .ovf_cnt     (ovf_cnt)
    );

endmodule

// File: rtl/acc_edge_stamper_chk.sv
module acc_edge_stamper_chk #(
    parameter int TS_W  = 64,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ts_load,
    input logic [TS_W-1:0]  ts_load_val,
    input logic [TS_W-1:0]  ts_now,
    input logic             strobe_rise,
    input logic             stream_emit,
    input logic             out_valid,
    input logic             out_ready,
    input logic [TS_W-1:0]  out_ts,
    input logic             out_src,
    input logic [CNT_W-1:0] drop_cnt,
    input logic [CNT_W-1:0] ovf_cnt
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && drop_cnt == '0 && ovf_cnt == '0)); // R1

    AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ts_load)) |-> ts_now == $past(ts_now) + TS_W'(1)); // R2

    AST_TS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ts_load)) |-> ts_now == $past(ts_load_val)); // R2

    AST_STROBE_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(strobe_rise) && !$past(out_valid && !out_ready))
        |-> (out_valid && out_src && out_ts == $past(ts_now))); // R5

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_ts) && $stable(out_src))); // R9

    AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && drop_cnt != $past(drop_cnt)) |-> $past(strobe_rise && stream_emit)); // R8

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ovf_cnt != $past(ovf_cnt)) |-> $past(out_valid && !out_ready)); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ovf_cnt >= $past(ovf_cnt) && drop_cnt >= $past(drop_cnt))); // R11
endmodule

bind acc_edge_stamper acc_edge_stamper_chk #(.TS_W(TS_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ts_load     (ts_load),
    .ts_load_val (ts_load_val),
    .ts_now      (ts_now),
    .strobe_rise (strobe_rise),
    .stream_emit (stream_emit),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_ts      (out_ts),
    .out_src     (out_src),
    .drop_cnt    (drop_cnt),
    .ovf_cnt     (ovf_cnt)
);

// File: tb/acc_edge_stamper_bench.sv
`timescale 1ns/1ps
module acc_edge_stamper_bench;
    localparam int TS_W  = 64;
    localparam int DEC_W = 4;
    localparam int CNT_W = 3;
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ld = 1'b0;
    logic [TS_W-1:0]  ld_val = '0;
    logic [DEC_W-1:0] decim = '0;
    logic             st_in = 1'b0;
    logic             sb_in = 1'b0;
    logic             rdy = 1'b1;
    logic             out_valid, out_src;
    logic [TS_W-1:0]  out_ts;
    logic [CNT_W-1:0] drop_cnt, ovf_cnt;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    int rec_st   = 0;
    int rec_sb   = 0;
    logic [TS_W-1:0] last_sb_ts = '0;

    always #2 clk = ~clk;

    acc_edge_stamper #(.TS_W(TS_W), .DEC_W(DEC_W), .CNT_W(CNT_W)) u_acc_edge_stamper (
        .clk(clk), .rst_n(rst_n), .ts_load(ld), .ts_load_val(ld_val), .decim_n(decim),
        .stream_in(st_in), .strobe_in(sb_in), .out_valid(out_valid), .out_ready(rdy),
        .out_ts(out_ts), .out_src(out_src), .drop_cnt(drop_cnt), .ovf_cnt(ovf_cnt)
    );

    // ---------------- reference model from the requirements ----------------
    logic [TS_W-1:0]  m_ts, m_ots;
    logic [2:0]       m_st, m_sb;
    logic [DEC_W-1:0] m_dcnt;
    logic             m_valid, m_osrc;
    logic [CNT_W-1:0] m_drop, m_ovf;

    function automatic logic [CNT_W-1:0] f_sat(input logic [CNT_W-1:0] c);
        return (c == CMAX) ? c : c + 1'b1;
    endfunction

    function automatic logic f_emit(input logic r, input logic [DEC_W-1:0] c, input logic [DEC_W-1:0] n);
        return r && (n != 0) && (c >= n - 1'b1);
    endfunction

    function automatic logic [DEC_W-1:0] f_next_cnt(input logic r, input logic [DEC_W-1:0] c,
                                                    input logic [DEC_W-1:0] n);
        if (n == 0) return '0;
        if (!r) return c;
        return f_emit(r, c, n) ? '0 : c + 1'b1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ts <= '0; m_ots <= '0; m_st <= '0; m_sb <= '0; m_dcnt <= '0;
            m_valid <= 1'b0; m_osrc <= 1'b0; m_drop <= '0; m_ovf <= '0;
        end else begin
            logic r_st, r_sb, em, cand, free;
            r_st = m_st[1] & ~m_st[2];
            r_sb = m_sb[1] & ~m_sb[2];
            em   = f_emit(r_st, m_dcnt, decim);
            cand = r_sb | em;
            free = !m_valid || rdy;
            m_dcnt <= f_next_cnt(r_st, m_dcnt, decim);
            m_st <= {m_st[1:0], st_in};
            m_sb <= {m_sb[1:0], sb_in};
            m_ts <= ld ? ld_val : m_ts + 1'b1;
            if (r_sb && em) m_drop <= f_sat(m_drop);
            if (cand && free) begin
                m_valid <= 1'b1; m_ots <= m_ts; m_osrc <= r_sb;
            end else if (cand) begin
                m_ovf <= f_sat(m_ovf);
            end else if (m_valid && rdy) begin
                m_valid <= 1'b0;
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string req, input logic [TS_W-1:0] act,
                       input logic [TS_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input string req);
        @(negedge clk);
        chk(out_valid === m_valid, {req, " valid"}, TS_W'(out_valid), TS_W'(m_valid));
        if (m_valid) begin
            chk(out_ts === m_ots, {req, " ts"}, out_ts, m_ots);
            chk(out_src === m_osrc, {req, " src"}, TS_W'(out_src), TS_W'(m_osrc));
        end
        chk(drop_cnt === m_drop, {req, " drop"}, TS_W'(drop_cnt), TS_W'(m_drop));
        chk(ovf_cnt === m_ovf, {req, " ovf"}, TS_W'(ovf_cnt), TS_W'(m_ovf));
        if (out_valid && rdy) begin
            if (out_src) begin rec_sb++; last_sb_ts = out_ts; end
            else rec_st++;
        end
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) cyc(req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int base_st, base_sb, lat;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!out_valid && drop_cnt == 0 && ovf_cnt == 0, "R1 reset", TS_W'(out_valid), 0);
        rst_n = 1'b1;
        cyc("R1");
        chk(!out_valid && drop_cnt == 0 && ovf_cnt == 0, "R1 after release", TS_W'(out_valid), 0);

        // R3: latency from first high sample to out_valid
        sb_in = 1'b1; lat = 0;
        do begin cyc("R3"); lat++; end while (!out_valid && lat < 10);
        chk(lat == 3, "R3 latency", TS_W'(lat), 3);
        sb_in = 1'b0; idle(4, "R3");

        // R2: load all-ones with a strobe, record carries wrapped value
        ld = 1'b1; ld_val = '1; sb_in = 1'b1;
        cyc("R2");
        ld = 1'b0;
        idle(4, "R2");
        chk(last_sb_ts == 0, "R2 load wrap", last_sb_ts, 0);
        sb_in = 1'b0; idle(4, "R2");

        // R4: long strobe level yields one record
        base_sb = rec_sb;
        sb_in = 1'b1; idle(20, "R4");
        sb_in = 1'b0; idle(20, "R4");
        chk(rec_sb - base_sb == 1, "R4 single record", TS_W'(rec_sb - base_sb), 1);

        // R6: N=3, 9 stream edges -> 3 records
        decim = 4'd3; base_st = rec_st;
        for (int e = 0; e < 9; e++) begin
            st_in = 1'b1; idle(2, "R6"); st_in = 1'b0; idle(2, "R6");
        end
        idle(4, "R6");
        chk(rec_st - base_st == 3, "R6 decimation", TS_W'(rec_st - base_st), 3);

        // R7: N=0 suppresses, then N=2 counts from cleared state
        decim = 4'd0; base_st = rec_st;
        for (int e = 0; e < 6; e++) begin
            st_in = 1'b1; idle(2, "R7"); st_in = 1'b0; idle(2, "R7");
        end
        idle(4, "R7");
        chk(rec_st == base_st, "R7 suppressed", TS_W'(rec_st - base_st), 0);
        decim = 4'd2;
        for (int e = 0; e < 4; e++) begin
            st_in = 1'b1; idle(2, "R7"); st_in = 1'b0; idle(2, "R7");
        end
        idle(4, "R7");
        chk(rec_st - base_st == 2, "R7 restart", TS_W'(rec_st - base_st), 2);

        // R8: simultaneous strobe and stream, N=1
        decim = 4'd1; base_st = rec_st; base_sb = rec_sb;
        st_in = 1'b1; sb_in = 1'b1; idle(3, "R8");
        st_in = 1'b0; sb_in = 1'b0; idle(4, "R8");
        chk(drop_cnt == 1 && rec_sb - base_sb == 1 && rec_st == base_st, "R8 priority",
            TS_W'(drop_cnt), 1);

        // R9 / R10 / R11: stall and overflow to saturation
        decim = 4'd0; rdy = 1'b0;
        for (int p = 0; p < 10; p++) begin
            sb_in = 1'b1; cyc("R9"); sb_in = 1'b0; idle(2, "R10");
        end
        idle(3, "R11");
        chk(ovf_cnt == CMAX, "R11 saturation", TS_W'(ovf_cnt), TS_W'(CMAX));
        chk(out_valid == 1'b1, "R9 held", TS_W'(out_valid), 1);
        rdy = 1'b1; idle(3, "R10");

        // R10: back-to-back replace while ready, no loss
        for (int p = 0; p < 4; p++) begin
            sb_in = ~sb_in; cyc("R10");
        end
        sb_in = 1'b0; idle(6, "R10");

        // randomized mix
        for (int i = 0; i < 4000; i++) begin
            st_in = $urandom_range(0, 1) == 1;
            sb_in = $urandom_range(0, 7) == 0 ? ~sb_in : sb_in;
            rdy   = $urandom_range(0, 3) != 0;
            ld    = $urandom_range(0, 99) == 0;
            ld_val = {$urandom, $urandom};
            if ($urandom_range(0, 199) == 0) decim = DEC_W'($urandom_range(0, 4));
            cyc("R10 random");
        end
        ld = 1'b0;
        idle(5, "R6 random");
        finish_run();
    end
endmodule